// File: doc/BRIEF.md
# Timer time base counter

This block is the counting core of a general-purpose timer. A prescaler divides the input clock, and on each divided tick a counter steps through a period bounded by a reload value. It can count upward with a wrap to zero, downward with a reload at zero, or up and down in a triangle. Every turn of the period produces an update event. The update event loads the buffered prescaler and reload values, sets a sticky interrupt flag and can raise a one-cycle DMA request.

Software programs the block through a single-cycle write port. Writes to address 0 set the control bits, address 1 holds the prescaler, address 2 holds the reload value, address 3 clears the flag and address 4 issues a software update. The counter value and the present counting direction are visible on the ports, so downstream compare logic can use them.

Top module: `tbase_counter`

## Requirements
- R1: After reset the count, the direction, the update event, the flag, the interrupt and the DMA request are all 0.
- R2: The counter takes one step every (P + 1) clock cycles, where P is the active prescaler. A prescaler written to address 1 becomes active only at the next update event.
- R3: With control bits 3:2 = 0 and bit 1 = 0 the counter counts up from 0 to the reload value R inclusive and then wraps to 0. The wrap is an update event, and the period is (P + 1)(R + 1) cycles.
- R4: With control bits 3:2 = 0 and bit 1 = 1 the counter counts down, and on a step at 0 it loads R. That step is an update event. The direction output is 1 while counting down.
- R5: Any nonzero value in control bits 3:2 selects up-down counting. The counter rises to R, turns, falls to 0 and turns again. Each turn is an update event, after which the count is R-1 (now falling) or 1 (now rising). Each half period is R steps, and the direction output follows the phase.
- R6: A write to control bits 3:2 is ignored while the counter runs (control bit 0 = 1 before the write).
- R7: Writing 1 to bit 0 of address 4 is a software update. It loads 0 into the counter, or loads R when counting down in edge mode. It also clears the prescaler count, loads the prescaler and reload buffers, and raises an update event.
- R8: With control bit 5 = 1 a software update sets neither the flag nor the DMA request. A counter wrap still sets both.
- R9: With control bit 4 = 1 a reload value written to address 2 takes effect at the next update event. With bit 4 = 0 it takes effect at once.
- R10: The update flag is set by each reported update and stays set until a write of 1 to bit 0 of address 3. A set in the same cycle wins over the clear. The interrupt output is the flag ANDed with control bit 6, and bit 6 is also driven out directly.
- R11: When control bit 7 = 1 the DMA request is high for exactly the cycles in which a reported update event occurs, and never without an update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Write data |
| count | output | CNT_W | Counter value |
| dir_down | output | 1 | 1 while counting down |
| upd_evt | output | 1 | One-cycle update event |
| upd_flag | output | 1 | Sticky update flag |
| upd_irq_en | output | 1 | Update interrupt enable (control bit 6) |
| upd_irq | output | 1 | Update interrupt request |
| dma_req | output | 1 | One-cycle update DMA request |

## Verification
The bench checks the count and direction at every update event, and the cycle distance between events. A prescaler count or a shadowed reload value that is off by one therefore shows up as a wrong period within one period of the fault. A stale up-down phase bit changes the count seen at the next turn, and an update that is wrongly reported shows up on the flag or the DMA request in the same cycle. A mode field that changes while the counter runs alters the event values at the very next turn.

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              dir_down,
  output logic              upd_evt,
  output logic              upd_flag,
  output logic              upd_irq_en,
  output logic              upd_irq,
  output logic              dma_req
);

  localparam logic [2:0] A_CTRL = 3'd0, A_PSC = 3'd1, A_ARR = 3'd2, A_CLR = 3'd3, A_UG = 3'd4;

  logic             run_q, dn_cfg_q, pre_q, urs_q, ie_q, de_q;
  logic [1:0]       cms_q;
  logic [PSC_W-1:0] psc_q, psc_sh, pcnt;
  logic [CNT_W-1:0] arr_q, arr_sh, cnt_q, cnt_n;
  logic             cdown_q, cd_n, ovf;

  wire wr_ctrl = wr_en && wr_addr == A_CTRL;
  wire wr_psc  = wr_en && wr_addr == A_PSC;
  wire wr_arr  = wr_en && wr_addr == A_ARR;
  wire wr_clr  = wr_en && wr_addr == A_CLR && wr_data[0];
  wire wr_ug   = wr_en && wr_addr == A_UG && wr_data[0];

  wire             center  = cms_q != 2'd0;
  wire [CNT_W-1:0] arr_act = pre_q ? arr_sh : arr_q;
  wire             tick    = run_q && pcnt == psc_sh;
  wire             upd_any = ovf || wr_ug;
  wire             rep     = ovf || (wr_ug && !urs_q);

  always_comb begin
    cnt_n = cnt_q;
    cd_n  = cdown_q;
    ovf   = 1'b0;
    if (tick) begin
      if (!center) begin
        if (!dn_cfg_q) begin
          if (cnt_q >= arr_act) begin cnt_n = '0; ovf = 1'b1; end
          else cnt_n = cnt_q + 1'b1;
        end else begin
          if (cnt_q == '0) begin cnt_n = arr_act; ovf = 1'b1; end
          else cnt_n = cnt_q - 1'b1;
        end
      end else if (arr_act == '0) begin
        cnt_n = '0;
        ovf   = 1'b1;
      end else if (!cdown_q) begin
        if (cnt_q >= arr_act) begin cnt_n = arr_act - 1'b1; cd_n = 1'b1; ovf = 1'b1; end
        else cnt_n = cnt_q + 1'b1;
      end else begin
        if (cnt_q == '0) begin cnt_n = CNT_W'(1); cd_n = 1'b0; ovf = 1'b1; end
        else cnt_n = cnt_q - 1'b1;
      end
    end
    if (wr_ug) begin
      cnt_n = (!center && dn_cfg_q) ? arr_q : '0;
      cd_n  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; dn_cfg_q <= 1'b0; cms_q <= 2'd0; pre_q <= 1'b0;
      urs_q <= 1'b0; ie_q <= 1'b0; de_q <= 1'b0;
      psc_q <= '0; psc_sh <= '0; pcnt <= '0;
      arr_q <= '0; arr_sh <= '0; cnt_q <= '0; cdown_q <= 1'b0;
      upd_evt <= 1'b0; upd_flag <= 1'b0; dma_req <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q    <= wr_data[0];
        dn_cfg_q <= wr_data[1];
        if (!run_q) cms_q <= wr_data[3:2];
        pre_q    <= wr_data[4];
        urs_q    <= wr_data[5];
        ie_q     <= wr_data[6];
        de_q     <= wr_data[7];
      end
      if (wr_psc) psc_q <= wr_data[PSC_W-1:0];
      if (wr_arr) arr_q <= wr_data[CNT_W-1:0];
      if (wr_ug || tick) pcnt <= '0;
      else if (run_q)    pcnt <= pcnt + 1'b1;
      if (upd_any) begin
        psc_sh <= psc_q;
        arr_sh <= arr_q;
      end
      cnt_q    <= cnt_n;
      cdown_q  <= cd_n;
      upd_evt  <= upd_any;
      dma_req  <= rep && de_q;
      upd_flag <= rep ? 1'b1 : (wr_clr ? 1'b0 : upd_flag);
    end
  end

  assign count      = cnt_q;
  assign dir_down   = center ? cdown_q : dn_cfg_q;
  assign upd_irq_en = ie_q;
  assign upd_irq    = upd_flag && ie_q;

endmodule

// File: rtl/tbase_counter_chk.sv
module tbase_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_wr,
  input logic             run_q,
  input logic [1:0]       cms_q,
  input logic [CNT_W-1:0] count,
  input logic             dir_down,
  input logic             upd_evt,
  input logic             upd_flag,
  input logic             dma_req
);

  AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_flag) |-> upd_evt); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_flag) && !$past(clr_wr)) |-> upd_flag); // R10

  AST_DMA_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> upd_evt); // R11

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_q) |-> $stable(cms_q)); // R6

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cms_q == 2'd0 && $past(cms_q) == 2'd0 && !dir_down && !$past(dir_down)
     && !upd_evt && count != $past(count)) |-> count == CNT_W'($past(count) + 1'b1)); // R3

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cms_q == 2'd0 && $past(cms_q) == 2'd0 && dir_down && $past(dir_down)
     && !upd_evt && count != $past(count)) |-> count == CNT_W'($past(count) - 1'b1)); // R4

endmodule

bind tbase_counter tbase_counter_chk #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rst_n(rst_n),
  .clr_wr(wr_en && wr_addr == 3'd3 && wr_data[0]),
  .run_q(run_q), .cms_q(cms_q), .count(count), .dir_down(dir_down),
  .upd_evt(upd_evt), .upd_flag(upd_flag), .dma_req(dma_req)
);

// File: tb/tbase_counter_test.sv
module tbase_counter_test;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic dir_down, upd_evt, upd_flag, upd_irq_en, upd_irq, dma_req;

  tbase_counter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .dir_down(dir_down), .upd_evt(upd_evt), .upd_flag(upd_flag),
    .upd_irq_en(upd_irq_en), .upd_irq(upd_irq), .dma_req(dma_req)
  );

  always #2.5 clk = ~clk;

  typedef struct { int cnt; bit dir; int gap; bit dma; string tag; } item_t;
  item_t exp_q[$];
  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(int c, bit d, int g, bit m, string t);
    item_t it;
    it.cnt = c; it.dir = d; it.gap = g; it.dma = m; it.tag = t;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    int cyc = 0, last = 0;
    item_t it;
    forever begin
      @(posedge clk); #1; cyc++;
      if (rst_n && !done) begin
        if (dma_req && !upd_evt) chk("R11 dma without event", 1, 0);
        if (upd_evt) begin
          if (exp_q.size() == 0) chk("R3 unexpected update event", count, -1);
          else begin
            it = exp_q.pop_front();
            chk({it.tag, " count"}, count, it.cnt);
            chk({it.tag, " direction"}, dir_down, it.dir);
            chk("R11 dma at event", dma_req, it.dma);
            if (it.gap != 0) chk({it.tag, " period"}, cyc - last, it.gap);
          end
          last = cyc;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 dir", dir_down, 0);
    chk("R1 event", upd_evt, 0);
    chk("R1 flag", upd_flag, 0);
    chk("R1 irq", upd_irq, 0);
    chk("R1 dma", dma_req, 0);
    rst_n = 1'b1;

    // edge up, prescaler 1, reload 4
    wr(0, 16'h00C0);
    chk("R10 irq enable out", upd_irq_en, 1);
    wr(1, 16'd1); wr(2, 16'd4);
    push(0, 0, 0, 1, "R7");
    wr(4, 16'd1);
    drain();
    chk("R10 flag set", upd_flag, 1);
    chk("R10 irq", upd_irq, 1);
    wr(3, 16'd1);
    chk("R10 flag cleared", upd_flag, 0);
    chk("R10 irq cleared", upd_irq, 0);
    push(0, 0, 0, 1, "R3"); push(0, 0, 10, 1, "R3"); push(0, 0, 10, 1, "R2");
    wr(0, 16'h00C1);
    drain();
    push(0, 0, 10, 1, "R2"); push(0, 0, 5, 1, "R2");
    wr(1, 16'd0);
    drain();
    wr(0, 16'h00C0);

    // edge down, reload 3
    wr(0, 16'h00C2); wr(2, 16'd3);
    push(3, 1, 0, 1, "R7");
    wr(4, 16'd1);
    drain();
    chk("R7 down load", count, 3);
    chk("R4 dir", dir_down, 1);
    push(3, 1, 0, 1, "R4"); push(3, 1, 4, 1, "R4"); push(3, 1, 4, 1, "R4");
    wr(0, 16'h00C3);
    drain();
    wr(0, 16'h00C2);

    // up-down, reload 3
    wr(0, 16'h00C4);
    push(0, 0, 0, 1, "R7");
    wr(4, 16'd1);
    drain();
    push(2, 1, 0, 1, "R5"); push(1, 0, 3, 1, "R5"); push(2, 1, 3, 1, "R5");
    wr(0, 16'h00C5);
    drain();
    push(1, 0, 3, 1, "R6"); push(2, 1, 3, 1, "R6"); push(1, 0, 3, 1, "R6");
    wr(0, 16'h00C1);
    drain();
    wr(0, 16'h00C0); wr(0, 16'h00C0);

    // reload buffered
    wr(0, 16'h00D0); wr(2, 16'd4);
    push(0, 0, 0, 1, "R7");
    wr(4, 16'd1);
    drain();
    push(0, 0, 0, 1, "R9"); push(0, 0, 5, 1, "R9");
    wr(0, 16'h00D1);
    drain();
    push(0, 0, 5, 1, "R9"); push(0, 0, 3, 1, "R9"); push(0, 0, 3, 1, "R9");
    wr(2, 16'd2);
    drain();
    wr(0, 16'h00D0);

    // reload immediate
    wr(0, 16'h00C0); wr(2, 16'd4);
    push(0, 0, 0, 1, "R7");
    wr(4, 16'd1);
    drain();
    push(0, 0, 0, 1, "R9");
    wr(0, 16'h00C1);
    drain();
    push(0, 0, 3, 1, "R9"); push(0, 0, 3, 1, "R9");
    wr(2, 16'd2);
    drain();
    wr(0, 16'h00C0);

    // counter-only update source
    wr(0, 16'h00E0); wr(3, 16'd1);
    chk("R10 flag cleared", upd_flag, 0);
    push(0, 0, 0, 0, "R8");
    wr(4, 16'd1);
    drain();
    chk("R8 flag after quiet update", upd_flag, 0);
    chk("R8 irq after quiet update", upd_irq, 0);
    push(0, 0, 0, 1, "R8");
    wr(0, 16'h00E1);
    drain();
    chk("R8 flag after wrap", upd_flag, 1);
    wr(0, 16'h00E0);

    repeat (4) @(negedge clk);
    chk("R3 leftover expected events", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule